// File: doc/BRIEF.md
# Clock Page Stealer Sweep Engine

This block walks a circular table of page-frame descriptors and decides, frame by frame, whether a frame is idle, recently used, ready to be taken back, or in need of a write-back before it can be taken. Two wrapping hands mark the span that a sweep covers. A sweep starts on a periodic timer pulse, or when the count of free frames drops under a low-water mark. After the span has been examined, the engine moves the hands forward by a configurable gap and clears the recently-used mark of every frame it passes on the way. That clearing gives those frames one full interval to show use again before the next sweep looks at them.

The descriptor table sits outside the block in a synchronous single-port RAM with a read latency of one cycle. The engine reads each frame once and writes it back at most once. It reports each reclaimed frame and each frame that needs a write-back as a one-cycle strobe that carries the frame index. An optional aging mode holds off reclaiming a frame until it has looked reclaimable on a set number of back-to-back examinations.

Top module: `clock_steal_engine`

## Requirements
- R1: A sweep starts when `tick` is high at a clock edge, or when `free_count < low_water` becomes true after having been false. While the free count stays below the mark, no further sweep starts.
- R2: `busy` rises the cycle after the trigger and stays high until the sweep ends. A sweep takes two cycles per examined frame plus two cycles per frame the end hand advances.
- R3: A sweep examines frames from `hand_start` up to but excluding `hand_end`, wrapping from NFRAMES-1 to 0. When the two hands are equal, all NFRAMES frames are examined.
- R4: Descriptor layout: bit 0 = valid, bit 1 = referenced, bit 2 = modified, bits [3 +: REFW] = reference count, bits [3+REFW +: AGEW] = age. A frame with valid 0 or reference count 0 is left unchanged and is not reported.
- R5: A valid, in-use frame with referenced 1 has its referenced bit and age cleared and is not reported.
- R6: A valid, in-use, unreferenced, unmodified frame that is due for reclaim raises `steal_vld` with its index in `steal_idx`. Its valid bit and age are cleared, and its other bits are kept.
- R7: A valid, in-use, unreferenced, modified frame raises `clean_vld` with its index in `clean_idx`, and its descriptor is left unchanged.
- R8: After the sweep, `hand_start` takes the old `hand_end`. `hand_end` then advances by `cfg_gap` frames modulo NFRAMES, and the referenced bit of each frame it passes is cleared with its other bits kept.
- R9: With `cfg_age_en` high, a reclaimable frame is stolen only when age+1 >= `cfg_age_limit`. Otherwise its age is incremented and it is not reported. A limit of 0 or 1 steals at once.
- R10: Triggers that arrive while busy are held as a single pending request. That request starts one new sweep after exactly one idle cycle.
- R11: The table port never reads and writes in the same cycle. A write only goes to the address read in the previous cycle. Each examined or passed frame is read exactly once.
- R12: After reset the engine is idle, `hand_start` is 0, `hand_end` is NFRAMES/2, and there is no table access and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Periodic sweep request |
| free_count | input | FREE_W | Current number of free frames |
| low_water | input | FREE_W | Low-water mark for free frames |
| cfg_gap | input | CNT_W | Frames the end hand advances per sweep |
| cfg_age_en | input | 1 | Enables aging before reclaim |
| cfg_age_limit | input | AGEW | Consecutive reclaimable examinations required |
| ft_addr | output | FIDX_W | Table address |
| ft_rd_en | output | 1 | Table read strobe |
| ft_wr_en | output | 1 | Table write strobe |
| ft_wdata | output | EW | Table write data |
| ft_rdata | input | EW | Table read data, valid one cycle after the read |
| busy | output | 1 | Sweep in progress |
| steal_vld | output | 1 | Frame reclaimed this cycle |
| steal_idx | output | FIDX_W | Index of the reclaimed frame |
| clean_vld | output | 1 | Frame needs write-back |
| clean_idx | output | FIDX_W | Index of the frame to clean |
| hand_start | output | FIDX_W | Start hand |
| hand_end | output | FIDX_W | End hand |

## Verification
The bench builds the engine with its defaults: 8 frames, a 2-bit reference count and a 2-bit age. At that size every gap from 0 to 8 can be applied, so both hand wraps happen, the equal-hands case that covers the whole ring is reached, and a table with random descriptors hits all four classifications within a few sweeps. The 2-bit age keeps the aging scenarios short: limits of 0 to 3, including a three-sweep run in which every frame is reclaimed only on its third look.

// File: rtl/csweep_pkg.sv
package csweep_pkg;
  typedef enum logic [2:0] {
    ACT_SKIP,
    ACT_REFCLR,
    ACT_CLEAN,
    ACT_AGE,
    ACT_STEAL
  } act_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN_RD,
    ST_SCAN_EV,
    ST_ADV_RD,
    ST_ADV_EV
  } st_e;
endpackage

// File: rtl/csweep_trigger.sv
module csweep_trigger #(
  parameter int FREE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [FREE_W-1:0] free_count,
  input  logic [FREE_W-1:0] low_water,
  input  logic              busy,
  output logic              go,
  output logic              req_evt
);
  logic below, below_q, pend_q;

  assign below   = free_count < low_water;
  assign req_evt = tick | (below & ~below_q);
  assign go      = ~busy & (req_evt | pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      below_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      below_q <= below;
      if (busy && req_evt) pend_q <= 1'b1;
      else if (go)         pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/csweep_classify.sv
module csweep_classify
  import csweep_pkg::*;
#(
  parameter int REFW = 2,
  parameter int AGEW = 2,
  localparam int EW = 3 + REFW + AGEW
) (
  input  logic [EW-1:0]   entry,
  input  logic            age_en,
  input  logic [AGEW-1:0] age_limit,
  output act_e            act,
  output logic [EW-1:0]   upd,
  output logic            need_wr
);
  localparam int AGE_LSB = 3 + REFW;

  logic            f_valid, f_ref, f_mod;
  logic [REFW-1:0] f_cnt;
  logic [AGEW-1:0] f_age;
  logic [AGEW:0]   age_next;

  assign f_valid  = entry[0];
  assign f_ref    = entry[1];
  assign f_mod    = entry[2];
  assign f_cnt    = entry[3 +: REFW];
  assign f_age    = entry[AGE_LSB +: AGEW];
  assign age_next = {1'b0, f_age} + 1'b1;

  always_comb begin
    upd     = entry;
    need_wr = 1'b0;
    act     = ACT_SKIP;
    if (!f_valid || f_cnt == '0) begin
      act = ACT_SKIP;
    end else if (f_ref) begin
      act                   = ACT_REFCLR;
      upd[1]                = 1'b0;
      upd[AGE_LSB +: AGEW]  = '0;
      need_wr               = 1'b1;
    end else if (f_mod) begin
      act = ACT_CLEAN;
    end else if (age_en && (age_next < {1'b0, age_limit})) begin
      act                   = ACT_AGE;
      upd[AGE_LSB +: AGEW]  = age_next[AGEW-1:0];
      need_wr               = 1'b1;
    end else begin
      act                   = ACT_STEAL;
      upd[0]                = 1'b0;
      upd[AGE_LSB +: AGEW]  = '0;
      need_wr               = 1'b1;
    end
  end
endmodule

// File: rtl/csweep_walker.sv
module csweep_walker
  import csweep_pkg::*;
#(
  parameter int NFRAMES = 8,
  parameter int EW      = 7,
  localparam int FIDX_W = $clog2(NFRAMES),
  localparam int CNT_W  = $clog2(NFRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CNT_W-1:0]  cfg_gap,
  input  logic [EW-1:0]     ft_rdata,
  input  act_e              cls_act,
  input  logic [EW-1:0]     cls_upd,
  input  logic              cls_wr,
  output logic [FIDX_W-1:0] ft_addr,
  output logic              ft_rd_en,
  output logic              ft_wr_en,
  output logic [EW-1:0]     ft_wdata,
  output logic              steal_vld,
  output logic              clean_vld,
  output logic              busy,
  output logic              last_step,
  output logic [FIDX_W-1:0] hand_start,
  output logic [FIDX_W-1:0] hand_end
);
  localparam logic [FIDX_W-1:0] LAST_IDX  = FIDX_W'(NFRAMES - 1);
  localparam logic [FIDX_W-1:0] INIT_END  = FIDX_W'(NFRAMES / 2);
  localparam logic [CNT_W-1:0]  RING_SIZE = CNT_W'(NFRAMES);

  function automatic logic [FIDX_W-1:0] ring_next(input logic [FIDX_W-1:0] idx);
    return (idx == LAST_IDX) ? '0 : idx + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] ring_span(input logic [FIDX_W-1:0] s,
                                                 input logic [FIDX_W-1:0] e);
    logic [CNT_W-1:0] d;
    d = CNT_W'(e) - CNT_W'(s);
    return (e > s) ? d : d + RING_SIZE;
  endfunction

  st_e               st;
  logic [FIDX_W-1:0] cur;
  logic [CNT_W-1:0]  cnt;

  assign busy      = (st != ST_IDLE);
  assign last_step = (cnt == CNT_W'(1));
  assign ft_addr   = cur;
  assign ft_rd_en  = (st == ST_SCAN_RD) || (st == ST_ADV_RD);
  assign ft_wr_en  = ((st == ST_SCAN_EV) && cls_wr) || ((st == ST_ADV_EV) && ft_rdata[1]);
  assign ft_wdata  = (st == ST_ADV_EV) ? (ft_rdata & ~EW'(2)) : cls_upd;
  assign steal_vld = (st == ST_SCAN_EV) && (cls_act == ACT_STEAL);
  assign clean_vld = (st == ST_SCAN_EV) && (cls_act == ACT_CLEAN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cur        <= '0;
      cnt        <= '0;
      hand_start <= '0;
      hand_end   <= INIT_END;
    end else begin
      unique case (st)
        ST_IDLE: if (go) begin
          st  <= ST_SCAN_RD;
          cur <= hand_start;
          cnt <= ring_span(hand_start, hand_end);
        end
        ST_SCAN_RD: st <= ST_SCAN_EV;
        ST_SCAN_EV: begin
          if (last_step) begin
            hand_start <= hand_end;
            cur        <= hand_end;
            cnt        <= cfg_gap;
            st         <= (cfg_gap == '0) ? ST_IDLE : ST_ADV_RD;
          end else begin
            cur <= ring_next(cur);
            cnt <= cnt - 1'b1;
            st  <= ST_SCAN_RD;
          end
        end
        ST_ADV_RD: st <= ST_ADV_EV;
        ST_ADV_EV: begin
          cur <= ring_next(cur);
          cnt <= cnt - 1'b1;
          if (last_step) begin
            hand_end <= ring_next(cur);
            st       <= ST_IDLE;
          end else begin
            st <= ST_ADV_RD;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clock_steal_engine.sv
module clock_steal_engine
  import csweep_pkg::*;
#(
  parameter int NFRAMES = 8,
  parameter int REFW    = 2,
  parameter int AGEW    = 2,
  parameter int FREE_W  = 4,
  localparam int FIDX_W = $clog2(NFRAMES),
  localparam int CNT_W  = $clog2(NFRAMES + 1),
  localparam int EW     = 3 + REFW + AGEW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [FREE_W-1:0] free_count,
  input  logic [FREE_W-1:0] low_water,
  input  logic [CNT_W-1:0]  cfg_gap,
  input  logic              cfg_age_en,
  input  logic [AGEW-1:0]   cfg_age_limit,
  output logic [FIDX_W-1:0] ft_addr,
  output logic              ft_rd_en,
  output logic              ft_wr_en,
  output logic [EW-1:0]     ft_wdata,
  input  logic [EW-1:0]     ft_rdata,
  output logic              busy,
  output logic              steal_vld,
  output logic [FIDX_W-1:0] steal_idx,
  output logic              clean_vld,
  output logic [FIDX_W-1:0] clean_idx,
  output logic [FIDX_W-1:0] hand_start,
  output logic [FIDX_W-1:0] hand_end
);
  logic          go, req_evt, last_step, cls_wr;
  act_e          cls_act;
  logic [EW-1:0] cls_upd;

  csweep_trigger #(.FREE_W(FREE_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .tick(tick), .free_count(free_count),
    .low_water(low_water), .busy(busy), .go(go), .req_evt(req_evt)
  );

  csweep_classify #(.REFW(REFW), .AGEW(AGEW)) u_cls (
    .entry(ft_rdata), .age_en(cfg_age_en), .age_limit(cfg_age_limit),
    .act(cls_act), .upd(cls_upd), .need_wr(cls_wr)
  );

  csweep_walker #(.NFRAMES(NFRAMES), .EW(EW)) u_walk (
    .clk(clk), .rst_n(rst_n), .go(go), .cfg_gap(cfg_gap), .ft_rdata(ft_rdata),
    .cls_act(cls_act), .cls_upd(cls_upd), .cls_wr(cls_wr),
    .ft_addr(ft_addr), .ft_rd_en(ft_rd_en), .ft_wr_en(ft_wr_en), .ft_wdata(ft_wdata),
    .steal_vld(steal_vld), .clean_vld(clean_vld), .busy(busy), .last_step(last_step),
    .hand_start(hand_start), .hand_end(hand_end)
  );

  assign steal_idx = ft_addr;
  assign clean_idx = ft_addr;
endmodule

// File: rtl/csweep_checker.sv
module csweep_checker #(
  parameter int FIDX_W = 3,
  parameter int EW     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ft_rd_en,
  input logic              ft_wr_en,
  input logic [FIDX_W-1:0] ft_addr,
  input logic [EW-1:0]     ft_wdata,
  input logic              steal_vld,
  input logic [FIDX_W-1:0] steal_idx,
  input logic              clean_vld,
  input logic [FIDX_W-1:0] clean_idx,
  input logic [FIDX_W-1:0] hand_start,
  input logic [FIDX_W-1:0] hand_end
);
  assert_port_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ft_rd_en && ft_wr_en));

  assert_write_follows_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ft_wr_en |-> ($past(ft_rd_en) && ft_addr == $past(ft_addr)));

  assert_steal_clears_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    steal_vld |-> (ft_wr_en && !ft_wdata[0] && ft_addr == steal_idx));

  assert_clean_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clean_vld |-> (!ft_wr_en && ft_addr == clean_idx));

  assert_single_report_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(steal_vld && clean_vld));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ft_rd_en && !ft_wr_en && !steal_vld && !clean_vld));

  assert_hands_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (busy || ($stable(hand_start) && $stable(hand_end))));
endmodule

bind clock_steal_engine csweep_checker #(.FIDX_W(FIDX_W), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ft_rd_en(ft_rd_en), .ft_wr_en(ft_wr_en),
  .ft_addr(ft_addr), .ft_wdata(ft_wdata), .steal_vld(steal_vld), .steal_idx(steal_idx),
  .clean_vld(clean_vld), .clean_idx(clean_idx), .hand_start(hand_start), .hand_end(hand_end)
);

// File: tb/clock_steal_engine_tb.sv
module clock_steal_engine_tb;
  localparam int NF = 8, REFW = 2, AGEW = 2, FREE_W = 4;
  localparam int FW = 3, CW = 4, EW = 3 + REFW + AGEW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tick, cfg_age_en;
  logic [FREE_W-1:0] free_count, low_water;
  logic [CW-1:0] cfg_gap;
  logic [AGEW-1:0] cfg_age_limit;
  logic [FW-1:0] ft_addr, steal_idx, clean_idx, hand_start, hand_end;
  logic ft_rd_en, ft_wr_en, busy, steal_vld, clean_vld;
  logic [EW-1:0] ft_wdata, ft_rdata;

  clock_steal_engine u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .free_count(free_count), .low_water(low_water),
    .cfg_gap(cfg_gap), .cfg_age_en(cfg_age_en), .cfg_age_limit(cfg_age_limit),
    .ft_addr(ft_addr), .ft_rd_en(ft_rd_en), .ft_wr_en(ft_wr_en), .ft_wdata(ft_wdata),
    .ft_rdata(ft_rdata), .busy(busy), .steal_vld(steal_vld), .steal_idx(steal_idx),
    .clean_vld(clean_vld), .clean_idx(clean_idx), .hand_start(hand_start), .hand_end(hand_end)
  );

  logic [EW-1:0] mem [NF];
  logic [EW-1:0] emem [NF];
  always @(posedge clk) begin
    if (ft_wr_en) mem[ft_addr] <= ft_wdata;
    if (ft_rd_en) ft_rdata <= mem[ft_addr];
  end

  int total = 0, fails = 0, cyc = 0;
  bit [NF-1:0] got_st, got_cl, exp_st, exp_cl;
  int n_st, n_rd, eh_s, eh_e, exp_busy, exp_rd, exp_vis;

  always @(negedge clk) if (rst_n && busy) begin
    if (steal_vld) begin got_st[steal_idx] = 1'b1; n_st++; end
    if (clean_vld) got_cl[clean_idx] = 1'b1;
    if (ft_rd_en) n_rd++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; fails++;
      $display("FAIL R2 watchdog: cycles %0d expected below %0d", cyc, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    got_st = '0; got_cl = '0; n_st = 0; n_rd = 0;
  endtask

  // reference sweep written from the requirements
  task automatic model(input int gap, input bit aen, input int lim);
    exp_vis = (eh_e - eh_s + NF) % NF;
    if (exp_vis == 0) exp_vis = NF;
    exp_st = '0; exp_cl = '0;
    for (int k = 0; k < exp_vis; k++) begin
      int i, age;
      logic [EW-1:0] e;
      i = (eh_s + k) % NF;
      e = emem[i];
      age = int'(e[6:5]);
      if (!e[0] || e[4:3] == 2'd0) begin
      end else if (e[1]) begin
        e[1] = 1'b0; e[6:5] = 2'd0;
      end else if (e[2]) begin
        exp_cl[i] = 1'b1;
      end else if (aen && (age + 1 < lim)) begin
        e[6:5] = 2'(age + 1);
      end else begin
        e[0] = 1'b0; e[6:5] = 2'd0; exp_st[i] = 1'b1;
      end
      emem[i] = e;
    end
    for (int k = 0; k < gap; k++) emem[(eh_e + k) % NF][1] = 1'b0;
    exp_busy = 2 * (exp_vis + gap);
    exp_rd = exp_vis + gap;
    eh_s = eh_e;
    eh_e = (eh_e + gap) % NF;
  endtask

  task automatic compare(input int bcyc);
    for (int i = 0; i < NF; i++)
      chk(mem[i] === emem[i], "R4 R5 R6 R7 R8 R9 descriptor", int'(mem[i]), int'(emem[i]));
    chk(got_st == exp_st, "R6 stolen set", int'(got_st), int'(exp_st));
    chk(got_cl == exp_cl, "R7 clean set", int'(got_cl), int'(exp_cl));
    chk(int'(hand_start) == eh_s, "R8 start hand", int'(hand_start), eh_s);
    chk(int'(hand_end) == eh_e, "R8 end hand", int'(hand_end), eh_e);
    chk(bcyc == exp_busy, "R2 busy length", bcyc, exp_busy);
    chk(n_rd == exp_rd, "R11 read count", n_rd, exp_rd);
  endtask

  task automatic pulse_and_wait(output int bcyc);
    clear_mon();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    bcyc = 0;
    while (busy && bcyc < 500) begin bcyc++; @(negedge clk); end
  endtask

  task automatic fill_random();
    for (int i = 0; i < NF; i++) begin mem[i] = EW'($urandom); emem[i] = mem[i]; end
  endtask

  initial begin
    int b, seen;
    rst_n = 1'b0; tick = 1'b0; free_count = 4'd10; low_water = 4'd3;
    cfg_gap = 4'd2; cfg_age_en = 1'b0; cfg_age_limit = 2'd0;
    for (int i = 0; i < NF; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(busy == 1'b0, "R12 idle after reset", int'(busy), 0);
    chk(hand_start == 3'd0, "R12 start hand", int'(hand_start), 0);
    chk(hand_end == 3'd4, "R12 end hand", int'(hand_end), 4);
    chk(!ft_rd_en && !ft_wr_en, "R12 no access", int'(ft_rd_en) + int'(ft_wr_en), 0);
    chk(!steal_vld && !clean_vld, "R12 no strobe", int'(steal_vld) + int'(clean_vld), 0);
    eh_s = 0; eh_e = 4;

    // random tables, every gap, aging on and off (R3 to R9)
    for (int s = 0; s < 12; s++) begin
      int g, full;
      g = s % 9;
      cfg_gap = CW'(g);
      cfg_age_en = (s >= 6);
      cfg_age_limit = AGEW'(s % 4);
      fill_random();
      model(g, s >= 6, s % 4);
      full = (exp_vis == NF);
      pulse_and_wait(b);
      compare(b);
      if (full) chk(n_rd == NF + g, "R3 equal hands cover ring", n_rd, NF + g);
    end

    // R9 directed aging: align hands, then three full sweeps
    cfg_gap = 4'd8; cfg_age_en = 1'b0;
    fill_random(); model(8, 1'b0, 0); pulse_and_wait(b); compare(b);
    for (int i = 0; i < NF; i++) begin mem[i] = 7'b0001001; emem[i] = mem[i]; end
    cfg_age_en = 1'b1; cfg_age_limit = 2'd3;
    for (int p = 1; p <= 3; p++) begin
      model(8, 1'b1, 3); pulse_and_wait(b); compare(b);
      chk(n_st == ((p == 3) ? NF : 0), "R9 steal on third look", n_st, (p == 3) ? NF : 0);
    end

    // R1 low-water trigger
    cfg_gap = 4'd1; cfg_age_en = 1'b0;
    fill_random(); model(1, 1'b0, 0); clear_mon();
    @(negedge clk); free_count = 4'd2;
    @(negedge clk);
    chk(busy == 1'b1, "R1 low-water start", int'(busy), 1);
    b = 0;
    while (busy && b < 500) begin b++; @(negedge clk); end
    compare(b);
    seen = 0;
    repeat (10) begin @(negedge clk); if (busy) seen++; end
    chk(seen == 0, "R1 no retrigger while below", seen, 0);
    free_count = 4'd10;

    // R10 triggers during a sweep collapse into one
    fill_random(); model(1, 1'b0, 0); clear_mon();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    b = 0;
    while (busy && b < 500) begin
      b++;
      tick = (b == 1 || b == 2);
      @(negedge clk);
    end
    tick = 1'b0;
    compare(b);
    chk(busy == 1'b0, "R10 one idle cycle", int'(busy), 0);
    clear_mon(); model(1, 1'b0, 0);
    @(negedge clk);
    chk(busy == 1'b1, "R10 pending sweep starts", int'(busy), 1);
    b = 0;
    while (busy && b < 500) begin b++; @(negedge clk); end
    compare(b);
    seen = 0;
    repeat (10) begin @(negedge clk); if (busy) seen++; end
    chk(seen == 0, "R10 serviced only once", seen, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule